// File: doc/BRIEF.md
# Dual-Tone Channel Sample Generator

This block produces the sample stream for one DAC output channel. Its main source is an internal generator that runs two independent tones. Each tone has its own phase accumulator, frequency increment, phase offset and signed gain. The two scaled tones are added and clipped to the sample width. A per-channel source code can replace the tone sum with samples streamed in from outside, or with a free-running 16-bit ramp.

Settings are written through a narrow register port. Tone settings go into staging registers and stay there until a synchronise bit is written. When that happens, every staged value becomes active in the same cycle and both accumulators restart from zero. A chip that drives the same synchronise write into several channels therefore starts all of them phase-aligned. A build parameter removes the tone datapath. A status pin then reports that the generator is absent, and tone settings have no effect.

Top module: `dual_tone_chan`

## Requirements
- R1: After reset `sample_out` is 0, all staged and active settings are 0, and the source code is 0 (tone).
- R2: A tone word sits at address 1 (tone A) or address 2 (tone B). Bits 15:0 hold the frequency increment and bits 31:16 hold the phase offset. The tone shape is a triangle of the phase p = accumulator + offset (mod 65536). With u = p when bit 15 of p is 0, and u = ~p (16 bits) otherwise, the shape value is 2·u − 32768.
- R3: Each cycle, a tone's accumulator adds its active frequency increment, modulo 65536.
- R4: A gain word sits at address 3 (tone A) or address 4 (tone B), bits 15:0. It is sign-magnitude 1.1.14: bit 15 is the sign and bits 14:0 are the magnitude in units of 1/16384. The scaled tone is floor(shape × magnitude / 16384), negated when the sign bit is 1.
- R5: The two scaled tones are added and saturated to the range −32768..32767.
- R6: Writes to addresses 1–4 do not change the output until the synchronise bit is written. That bit is bit 0 at address 0. The synchronise action loads all four staged values and resets both accumulators to 0. The first sample from the reset accumulators appears on `sample_out` three clock edges after the synchronise write.
- R7: The synchronise request lasts a single cycle and clears itself. A staged write made after a synchronise is not applied without a new synchronise.
- R8: A tone word whose frequency field is above 0x8000 (half the sample rate) is discarded whole, offset included. A frequency field of exactly 0x8000 is accepted.
- R9: The source code is bits 3:0 at address 5 and acts immediately. Code 0 selects the tone sum. Code 2 selects `stream_in`, which appears on `sample_out` one clock edge later. Code 11 selects the ramp.
- R10: The ramp rises by 1 every cycle and wraps from 0xFFFF to 0x0000.
- R11: Any other source code drives `sample_out` to 0.
- R12: With `TONE_EN` = 0, `tone_absent` is 1 and source code 0 outputs 0 whatever the tone settings are. With `TONE_EN` = 1, `tone_absent` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Register write data |
| stream_in | input | 16 | Externally streamed sample |
| sample_out | output | 16 | Channel output sample (two's complement for tones) |
| tone_absent | output | 1 | High when the tone generator is built out |

## Verification
Each result has a fixed delay after its stimulus:
- A streamed sample reaches `sample_out` one edge after it is driven.
- A source change is visible one edge after the write.
- A tone setting reaches the output three edges after the synchronise write, passing through the active registers, the sum register and the output register.

The bench drives inputs on the falling edge and reads outputs on the falling edge.

Static tone values are checked only after at least eight cycles have passed, so the pipeline has settled. The restart check counts exactly three edges and then five more. The frequency-dependent checks use differences between consecutive samples, which do not depend on absolute alignment. The ramp check runs through a full wrap.

// File: rtl/dds_pkg.sv
`timescale 1ns/1ps
package dds_pkg;
   // register map (offsets decoded by the channel register file)
   localparam int unsigned REG_ADDR_W = 3;
   localparam int unsigned NUM_TONES  = 2;
   localparam logic [REG_ADDR_W-1:0] A_CTRL      = 3'd0;
   localparam logic [REG_ADDR_W-1:0] A_WORD_BASE = 3'd1;
   localparam logic [REG_ADDR_W-1:0] A_GAIN_BASE = 3'd3;
   localparam logic [REG_ADDR_W-1:0] A_SRC       = 3'd5;

   // output source codes
   localparam int unsigned SRC_W = 4;
   localparam logic [SRC_W-1:0] SRC_TONE   = 4'd0;
   localparam logic [SRC_W-1:0] SRC_STREAM = 4'd2;
   localparam logic [SRC_W-1:0] SRC_RAMP   = 4'd11;

   // gain format: sign-magnitude, one integer bit, GAIN_FRAC fraction bits
   localparam int unsigned GAIN_W    = 16;
   localparam int unsigned GAIN_FRAC = 14;
   typedef struct packed {
      logic                neg;
      logic [GAIN_W-2:0]   mag;
   } gain_t;
endpackage

// File: rtl/dds_regs.sv
`timescale 1ns/1ps
module dds_regs
   import dds_pkg::*;
#(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned PHASE_W = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [REG_ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0]     wr_data,
   output logic                  sync_pend,
   output logic [SRC_W-1:0]      src_sel,
   output logic [PHASE_W-1:0]    act_freq [NUM_TONES],
   output logic [PHASE_W-1:0]    act_ofs  [NUM_TONES],
   output gain_t                 act_gain [NUM_TONES]
);
   localparam int unsigned HALF = DATA_W / 2;
   localparam logic [PHASE_W-1:0] NYQ = PHASE_W'(1) << (PHASE_W - 1);

   if (PHASE_W > HALF) begin : g_bad_phase
      $error("dds_regs: PHASE_W must fit in half a data word");
   end
   if (GAIN_W > DATA_W || SRC_W > DATA_W) begin : g_bad_data
      $error("dds_regs: data word too narrow for gain or source fields");
   end
   if (PHASE_W < 3) begin : g_bad_small
      $error("dds_regs: PHASE_W must be at least 3");
   end

   logic sync_wr;
   assign sync_wr = wr_en && (wr_addr == A_CTRL) && wr_data[0];

   // one-cycle synchronise request
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_pend <= 1'b0;
      else        sync_pend <= sync_wr;
   end

   // source select acts without synchronise
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          src_sel <= SRC_TONE;
      else if (wr_en && wr_addr == A_SRC)  src_sel <= wr_data[SRC_W-1:0];
   end

   for (genvar t = 0; t < NUM_TONES; t++) begin : g_tone
      localparam logic [REG_ADDR_W-1:0] A_WORD = A_WORD_BASE + REG_ADDR_W'(t);
      localparam logic [REG_ADDR_W-1:0] A_GAIN = A_GAIN_BASE + REG_ADDR_W'(t);

      logic [PHASE_W-1:0] new_freq;
      logic [PHASE_W-1:0] st_freq, st_ofs, ac_freq, ac_ofs;
      gain_t              st_gain, ac_gain;
      logic               word_ok;

      assign new_freq = wr_data[PHASE_W-1:0];
      assign word_ok  = wr_en && (wr_addr == A_WORD) && (new_freq <= NYQ);

      // staging registers
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            st_freq <= '0;
            st_ofs  <= '0;
            st_gain <= '0;
         end else begin
            if (word_ok) begin
               st_freq <= new_freq;
               st_ofs  <= wr_data[HALF +: PHASE_W];
            end
            if (wr_en && wr_addr == A_GAIN)
               st_gain <= gain_t'(wr_data[GAIN_W-1:0]);
         end
      end

      // active registers, loaded together on synchronise
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ac_freq <= '0;
            ac_ofs  <= '0;
            ac_gain <= '0;
         end else if (sync_pend) begin
            ac_freq <= st_freq;
            ac_ofs  <= st_ofs;
            ac_gain <= st_gain;
         end
      end

      assign act_freq[t] = ac_freq;
      assign act_ofs[t]  = ac_ofs;
      assign act_gain[t] = ac_gain;
   end
endmodule

// File: rtl/dds_tone.sv
`timescale 1ns/1ps
module dds_tone
   import dds_pkg::*;
#(
   parameter int unsigned PHASE_W  = 16,
   parameter int unsigned SAMPLE_W = 16,
   parameter int unsigned SHAPE    = 0    // 0: triangle, 1: sawtooth
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       restart,
   input  logic [PHASE_W-1:0]         freq,
   input  logic [PHASE_W-1:0]         ofs,
   input  gain_t                      gain,
   output logic signed [SAMPLE_W+1:0] scaled
);
   localparam int unsigned PROD_W = SAMPLE_W + GAIN_W;

   if (PHASE_W < SAMPLE_W) begin : g_bad_width
      $error("dds_tone: PHASE_W must be at least SAMPLE_W");
   end
   if (SHAPE > 1) begin : g_bad_shape
      $error("dds_tone: unknown SHAPE");
   end

   logic [PHASE_W-1:0]         acc, ph, shape_full;
   logic signed [SAMPLE_W-1:0] wave;
   logic signed [PROD_W-1:0]   prod;
   logic signed [SAMPLE_W+1:0] mag_part;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       acc <= '0;
      else if (restart) acc <= '0;
      else              acc <= acc + freq;
   end

   assign ph = acc + ofs;

   if (SHAPE == 0) begin : g_tri
      logic [PHASE_W-2:0] fold;
      assign fold       = ph[PHASE_W-2:0] ^ {(PHASE_W-1){ph[PHASE_W-1]}};
      assign shape_full = {~fold[PHASE_W-2], fold[PHASE_W-3:0], 1'b0};
   end else begin : g_saw
      assign shape_full = {~ph[PHASE_W-1], ph[PHASE_W-2:0]};
   end

   assign wave     = signed'(shape_full[PHASE_W-1 -: SAMPLE_W]);
   assign prod     = wave * $signed({1'b0, gain.mag});
   assign mag_part = (SAMPLE_W+2)'(prod >>> GAIN_FRAC);
   assign scaled   = gain.neg ? -mag_part : mag_part;
endmodule

// File: rtl/dds_mix.sv
`timescale 1ns/1ps
module dds_mix
   import dds_pkg::*;
#(
   parameter int unsigned SAMPLE_W = 16,
   parameter bit          TONE_EN  = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic signed [SAMPLE_W+1:0] tone_in [NUM_TONES],
   input  logic [SRC_W-1:0]           src_sel,
   input  logic [SAMPLE_W-1:0]        stream_in,
   output logic [SAMPLE_W-1:0]        sample_out
);
   localparam int unsigned SUM_W = SAMPLE_W + 3;
   localparam logic signed [SUM_W-1:0] HI_LIM = SUM_W'(2 ** (SAMPLE_W - 1) - 1);
   localparam logic signed [SUM_W-1:0] LO_LIM = -HI_LIM - SUM_W'(1);
   localparam logic [SAMPLE_W-1:0] HI_OUT = {1'b0, {(SAMPLE_W-1){1'b1}}};
   localparam logic [SAMPLE_W-1:0] LO_OUT = {1'b1, {(SAMPLE_W-1){1'b0}}};

   logic [SAMPLE_W-1:0] tone_d, tone_q, ramp_q;

   if (TONE_EN) begin : g_sum
      logic signed [SUM_W-1:0] total;
      always_comb begin
         total = '0;
         for (int t = 0; t < NUM_TONES; t++)
            total = total + SUM_W'(tone_in[t]);
         if (total > HI_LIM)      tone_d = HI_OUT;
         else if (total < LO_LIM) tone_d = LO_OUT;
         else                     tone_d = total[SAMPLE_W-1:0];
      end
   end else begin : g_nosum
      assign tone_d = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tone_q <= '0;
         ramp_q <= '0;
      end else begin
         tone_q <= tone_d;
         ramp_q <= ramp_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sample_out <= '0;
      else begin
         case (src_sel)
            SRC_TONE:   sample_out <= tone_q;
            SRC_STREAM: sample_out <= stream_in;
            SRC_RAMP:   sample_out <= ramp_q;
            default:    sample_out <= '0;
         endcase
      end
   end
endmodule

// File: rtl/dual_tone_chan.sv
`timescale 1ns/1ps
module dual_tone_chan
   import dds_pkg::*;
#(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned PHASE_W    = 16,
   parameter int unsigned SAMPLE_W   = 16,
   parameter bit          TONE_EN    = 1'b1,
   parameter int unsigned WAVE_SHAPE = 0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [REG_ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0]     wr_data,
   input  logic [SAMPLE_W-1:0]   stream_in,
   output logic [SAMPLE_W-1:0]   sample_out,
   output logic                  tone_absent
);
   logic                       sync_pend;
   logic [SRC_W-1:0]           src_sel;
   logic [PHASE_W-1:0]         act_freq [NUM_TONES];
   logic [PHASE_W-1:0]         act_ofs  [NUM_TONES];
   gain_t                      act_gain [NUM_TONES];
   logic signed [SAMPLE_W+1:0] tone_val [NUM_TONES];

   assign tone_absent = !TONE_EN;

   dds_regs #(.DATA_W(DATA_W), .PHASE_W(PHASE_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .sync_pend(sync_pend), .src_sel(src_sel),
      .act_freq(act_freq), .act_ofs(act_ofs), .act_gain(act_gain)
   );

   if (TONE_EN) begin : g_tones
      for (genvar t = 0; t < NUM_TONES; t++) begin : g_t
         dds_tone #(.PHASE_W(PHASE_W), .SAMPLE_W(SAMPLE_W), .SHAPE(WAVE_SHAPE)) u_tone (
            .clk(clk), .rst_n(rst_n), .restart(sync_pend),
            .freq(act_freq[t]), .ofs(act_ofs[t]), .gain(act_gain[t]),
            .scaled(tone_val[t])
         );
      end
   end else begin : g_no_tones
      for (genvar t = 0; t < NUM_TONES; t++) begin : g_z
         assign tone_val[t] = '0;
      end
   end

   dds_mix #(.SAMPLE_W(SAMPLE_W), .TONE_EN(TONE_EN)) u_mix (
      .clk(clk), .rst_n(rst_n), .tone_in(tone_val), .src_sel(src_sel),
      .stream_in(stream_in), .sample_out(sample_out)
   );
endmodule

// File: rtl/dual_tone_chan_chk.sv
`timescale 1ns/1ps
module dual_tone_chan_chk
   import dds_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned PHASE_W  = 16,
   parameter int unsigned SAMPLE_W = 16,
   parameter bit          TONE_EN  = 1'b1
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  wr_en,
   input logic [REG_ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0]     wr_data,
   input logic [SAMPLE_W-1:0]   stream_in,
   input logic [SAMPLE_W-1:0]   sample_out,
   input logic                  sync_pend,
   input logic [SRC_W-1:0]      src_sel,
   input logic [PHASE_W-1:0]    act_freq [NUM_TONES],
   input logic [PHASE_W-1:0]    act_ofs  [NUM_TONES],
   input gain_t                 act_gain [NUM_TONES]
);
   localparam logic [PHASE_W-1:0] NYQ = PHASE_W'(1) << (PHASE_W - 1);

   logic sync_wr;
   assign sync_wr = wr_en && (wr_addr == A_CTRL) && wr_data[0];

   // R7
   sync_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sync_wr |=> sync_pend);

   // R7
   sync_selfclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_pend && !sync_wr) |=> !sync_pend);

   for (genvar t = 0; t < NUM_TONES; t++) begin : g_t
      // R6
      active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !sync_pend |=> ($stable(act_freq[t]) && $stable(act_ofs[t]) && $stable(act_gain[t])));

      // R8
      nyquist_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
         act_freq[t] <= NYQ);
   end

   // R9
   stream_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (src_sel == SRC_STREAM) |=> (sample_out == $past(stream_in)));

   // R10
   ramp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (src_sel == SRC_RAMP && $past(src_sel) == SRC_RAMP)
         |=> (sample_out == $past(sample_out) + 1'b1));

   // R11
   reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (src_sel != SRC_TONE && src_sel != SRC_STREAM && src_sel != SRC_RAMP)
         |=> (sample_out == '0));

   if (!TONE_EN) begin : g_absent
      // R12
      absent_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (src_sel == SRC_TONE) |=> (sample_out == '0));
   end
endmodule

bind dual_tone_chan dual_tone_chan_chk #(
   .DATA_W(DATA_W), .PHASE_W(PHASE_W), .SAMPLE_W(SAMPLE_W), .TONE_EN(TONE_EN)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
   .stream_in(stream_in), .sample_out(sample_out), .sync_pend(sync_pend),
   .src_sel(src_sel), .act_freq(act_freq), .act_ofs(act_ofs), .act_gain(act_gain)
);

// File: tb/dual_tone_chan_tb.sv
`timescale 1ns/1ps
module dual_tone_chan_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [15:0] stream_in = '0;
   logic [15:0] sample_out, nt_out;
   logic        tone_absent, nt_absent;
   int          n_chk = 0;
   int          n_err = 0;
   bit          done = 1'b0;

   always #2.5 clk = ~clk;

   dual_tone_chan u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .stream_in(stream_in), .sample_out(sample_out), .tone_absent(tone_absent)
   );

   dual_tone_chan #(.TONE_EN(1'b0)) u_dut_nt (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .stream_in(stream_in), .sample_out(nt_out), .tone_absent(nt_absent)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%0d (0x%04h) expected=%0d (0x%04h)",
                  req, $signed(act), act, $signed(exp), exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic sync_all();
      wr(3'd0, 32'd1);
   endtask

   task automatic settle();
      repeat (8) @(negedge clk);
   endtask

   function automatic longint shape(input int p);
      int u;
      u = (p & 32'h8000) != 0 ? (~p) & 32'hFFFF : p & 32'hFFFF;
      return longint'(2 * u - 32768);
   endfunction

   function automatic longint scale(input int p, input int g);
      longint v;
      v = (shape(p) * longint'(g & 32'h7FFF)) >>> 14;
      return (g & 32'h8000) != 0 ? -v : v;
   endfunction

   function automatic logic [15:0] expect2(input int pa, input int ga, input int pb, input int gb);
      longint s;
      s = scale(pa, ga) + scale(pb, gb);
      if (s > 32767) s = 32767;
      if (s < -32768) s = -32768;
      return 16'(s);
   endfunction

   task automatic setup(input int pa, input int ga, input int pb, input int gb);
      wr(3'd1, {16'(pa), 16'h0000});
      wr(3'd2, {16'(pb), 16'h0000});
      wr(3'd3, {16'h0, 16'(ga)});
      wr(3'd4, {16'h0, 16'(gb)});
      sync_all();
      settle();
   endtask

   task automatic t_reset();
      chk("R1 reset output", sample_out, 16'h0000);
      chk("R12 tone_absent low when built in", {15'h0, tone_absent}, 16'h0000);
      chk("R12 tone_absent high when built out", {15'h0, nt_absent}, 16'h0001);
   endtask

   task automatic t_static();
      setup(32'h6000, 32'h4000, 0, 0);
      chk("R2 single tone unity gain", sample_out, expect2(32'h6000, 32'h4000, 0, 0));
      chk("R12 built-out tone source gives zero", nt_out, 16'h0000);
      setup(32'h6000, 32'hC000, 0, 0);
      chk("R4 negative unity gain", sample_out, expect2(32'h6000, 32'hC000, 0, 0));
      setup(32'h6000, 32'h2000, 0, 0);
      chk("R4 half gain", sample_out, expect2(32'h6000, 32'h2000, 0, 0));
      setup(32'h2001, 32'h8001, 0, 0);
      chk("R4 floor then negate", sample_out, expect2(32'h2001, 32'h8001, 0, 0));
   endtask

   task automatic t_sum();
      setup(32'h6000, 32'h4000, 32'h6000, 32'h2000);
      chk("R5 two tones added", sample_out, expect2(32'h6000, 32'h4000, 32'h6000, 32'h2000));
      setup(32'h6000, 32'h4000, 32'h6000, 32'hA000);
      chk("R5 tone B subtracts", sample_out, expect2(32'h6000, 32'h4000, 32'h6000, 32'hA000));
      setup(32'h7FFF, 32'h7FFF, 32'h7FFF, 32'h7FFF);
      chk("R5 positive saturation", sample_out, 16'h7FFF);
      setup(0, 32'h7FFF, 0, 32'h7FFF);
      chk("R5 negative saturation", sample_out, 16'h8000);
   endtask

   task automatic t_hold();
      setup(32'h6000, 32'h4000, 0, 0);
      wr(3'd1, {16'h2000, 16'h0000});
      repeat (20) @(negedge clk);
      chk("R6 R7 staged offset not applied", sample_out, expect2(32'h6000, 32'h4000, 0, 0));
      sync_all();
      settle();
      chk("R6 staged offset applied on sync", sample_out, expect2(32'h2000, 32'h4000, 0, 0));
   endtask

   task automatic t_accum();
      logic [15:0] s0, s1, s2;
      wr(3'd1, {16'h0000, 16'h0010});
      wr(3'd3, 32'h4000);
      wr(3'd4, 32'h0000);
      sync_all();
      repeat (3) @(negedge clk);
      chk("R6 restart: first sample from zero phase", sample_out, 16'h8000);
      repeat (5) @(negedge clk);
      chk("R6 R3 fifth step after restart", sample_out, 16'(-32768 + 5 * 32));
      s0 = sample_out; @(negedge clk); s1 = sample_out; @(negedge clk); s2 = sample_out;
      chk("R3 step 1", 16'(s1 - s0), 16'd32);
      chk("R3 step 2", 16'(s2 - s1), 16'd32);
      // over-limit frequency must be discarded whole
      wr(3'd1, {16'h4000, 16'h8001});
      sync_all();
      settle();
      s0 = sample_out; @(negedge clk); s1 = sample_out;
      chk("R8 over-limit word discarded", 16'(s1 - s0), 16'd32);
      // exactly half the sample rate is accepted
      wr(3'd1, {16'h0000, 16'h8000});
      sync_all();
      settle();
      s0 = sample_out; @(negedge clk); s1 = sample_out; @(negedge clk); s2 = sample_out;
      chk("R8 limit frequency value set", s0, (s0 == 16'h8000) ? 16'h8000 : 16'd32766);
      chk("R8 limit frequency alternates", s1, (s0 == 16'h8000) ? 16'd32766 : 16'h8000);
      chk("R8 limit frequency period two", s2, s0);
   endtask

   task automatic t_source();
      wr(3'd5, 32'd2);
      @(negedge clk); stream_in = 16'h1234;
      @(negedge clk);
      chk("R9 stream passes after one edge", sample_out, 16'h1234);
      stream_in = 16'hBEEF;
      @(negedge clk);
      chk("R9 stream second value", sample_out, 16'hBEEF);
      wr(3'd5, 32'd7);
      settle();
      chk("R11 reserved code 7 gives zero", sample_out, 16'h0000);
      wr(3'd5, 32'd15);
      settle();
      chk("R11 reserved code 15 gives zero", sample_out, 16'h0000);
      setup(32'h6000, 32'h4000, 0, 0);
      wr(3'd5, 32'd0);
      settle();
      chk("R9 code 0 returns to tone", sample_out, expect2(32'h6000, 32'h4000, 0, 0));
   endtask

   task automatic t_ramp();
      logic [15:0] prev;
      int bad = 0;
      bit wrapped = 1'b0;
      wr(3'd5, 32'd11);
      settle();
      prev = sample_out;
      for (int i = 0; i < 66000; i++) begin
         @(negedge clk);
         if (sample_out !== 16'(prev + 16'd1)) bad++;
         if (prev == 16'hFFFF && sample_out == 16'h0000) wrapped = 1'b1;
         prev = sample_out;
      end
      chk("R10 ramp step errors", 16'(bad), 16'd0);
      chk("R10 ramp wrapped to zero", {15'h0, wrapped}, 16'h0001);
      wr(3'd5, 32'd0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_static();
      t_sum();
      t_hold();
      t_accum();
      t_source();
      t_ramp();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog (all requirements): actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule